// File: doc/BRIEF.md
# Masked Clear-on-Read Interrupt Status Unit

This block gathers single-cycle event pulses from a serial link controller into a set of status registers. A host processor reads these registers over a simple synchronous register port. Each primary source has its own mask bit. A source whose mask bit is 1 is kept pending but reads as zero. It shows up on the first read after its mask bit returns to 0. The block drives one interrupt line, which is high while any pending bit has its mask bit at 0.

The register port has four locations:

| Address | Register | Access |
|---|---|---|
| 0 | Primary status | read, clear-on-read |
| 1 | Mask | read/write |
| 2 | Extended status | read, clear-on-read |
| 3 | Line code | read |

Two primary bits behave differently from the others. Bit 0 is a summary bit for the extended status register, and only a read of location 2 or a primary read clears it. Bit 2 records a change in the line code. It is visible even when masked, and only a read of location 3 clears it. Read data is combinational: it is valid in the cycle in which `bus_rd` is high, and the clearing side effect takes place at that cycle's rising clock edge. The unit has no streaming data path, so every pin is a plain level or strobe.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, all primary status bits, all extended status bits and the line code are 0, the mask register reads 8'hFF, and `irq` is low.
- R2: A pulse on `ev_main[i]` sets primary bit i for every i other than 0 and 2. A read of location 0 returns those bits ANDed with the inverted mask, and clears each of them whose mask bit is 0.
- R3: A primary bit whose mask bit is 1 reads as 0. It stays pending across reads of location 0 and becomes readable once its mask bit is written to 0.
- R4: A pulse on `ci_evt` latches `ci_code` and sets primary bit 2. Bit 2 reads as 1 even while masked, and reads of location 0 do not clear it. A read of location 3 returns the latched code and clears bit 2.
- R5: Location 2 records every `ev_ext` pulse regardless of the mask. Reading location 2 clears it and also clears primary bit 0.
- R6: Primary bit 0 is set by any `ev_ext` pulse that arrives while mask bit 0 is 0. An extended event that arrives while mask bit 0 is 1 leaves bit 0 clear, and bit 0 stays clear after the mask bit is later cleared.
- R7: `irq` is high exactly when some primary bit is set while its mask bit is 0. A masked line-code change does not raise `irq`.
- R8: When a new event and a clearing read reach the same bit in the same cycle, the bit is set after that edge.
- R9: Location 1 reads back the last value written to it through `bus_wr`.
- R10: Pulses on `ev_main[0]` and `ev_main[2]` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe; the side effect occurs at this cycle's edge |
| bus_wr | input | 1 | Write strobe (only location 1 is writable) |
| bus_addr | input | 2 | Register location 0..3 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when `bus_rd` is low |
| ev_main | input | 8 | Primary event pulses (bits 0 and 2 ignored) |
| ev_ext | input | 8 | Extended event pulses |
| ci_evt | input | 1 | Line-code change pulse |
| ci_code | input | 6 | New line code, sampled on `ci_evt` |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest situations to reach from the ports are the same-edge collisions: an event pulse arriving in the very cycle that a read clears the same bit. This has to be exercised separately for an ordinary bit, for the extended summary bit and for the line-code bit. The stimulus table issues each read together with the matching event pulse, then reads the register again in the next cycle to confirm that the bit survived. Hidden pending state is reached by masking a bit, firing its event, reading repeatedly, and only then unmasking it. The case of an extended event arriving while the summary bit is masked is shown to leave nothing pending.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int REG_W   = 8;
  localparam int CI_W    = 6;
  localparam int EXD_POS = 0;
  localparam int CIC_POS = 2;

  typedef enum logic [1:0] {
    SEL_MAIN = 2'd0,
    SEL_MASK = 2'd1,
    SEL_EXT  = 2'd2,
    SEL_CODE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_ext_stat.sv
module irq_ext_stat #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ev_ext,
  input  logic          rd_ext,
  output logic [DW-1:0] ext_q,
  output logic          ext_hit
);
  // A new event wins over the clearing read in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= ev_ext | (ext_q & {DW{~rd_ext}});
  end

  assign ext_hit = |ev_ext;
endmodule

// File: rtl/irq_code_hold.sv
module irq_code_hold #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ci_evt,
  input  logic [CW-1:0] ci_code,
  output logic [CW-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      code_q <= '0;
    else if (ci_evt) code_q <= ci_code;
  end
endmodule

// File: rtl/irq_main_stat.sv
module irq_main_stat #(
  parameter int DW      = 8,
  parameter int EXD_BIT = 0,
  parameter int CIC_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ev_main,
  input  logic          ext_hit,
  input  logic          ci_evt,
  input  logic          rd_main,
  input  logic          rd_ext,
  input  logic          rd_code,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] pend_q,
  output logic [DW-1:0] view
);
  logic [DW-1:0] set_v, clr_v;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    localparam bit IS_EXD = (i == EXD_BIT);
    localparam bit IS_CIC = (i == CIC_BIT);
    localparam bit IS_NRM = !(IS_EXD || IS_CIC);

    // Set sources: ordinary pulse, summary of extended events, code change.
    assign set_v[i] = (ev_main[i] & IS_NRM)
                    | (ext_hit & ~mask[i] & IS_EXD)
                    | (ci_evt & IS_CIC);

    // Clear sources: unmasked primary read (not for the code bit),
    // extended read for the summary bit, code read for the code bit.
    assign clr_v[i] = (rd_main & ~mask[i] & ~IS_CIC)
                    | (rd_ext & IS_EXD)
                    | (rd_code & IS_CIC);

    // The code-change bit is visible whatever its mask says.
    assign view[i] = IS_CIC ? pend_q[i] : (pend_q[i] & ~mask[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= set_v[i] | (pend_q[i] & ~clr_v[i]);
    end
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int DW      = REG_W,
  parameter int CW      = CI_W,
  parameter int EXD_BIT = EXD_POS,
  parameter int CIC_BIT = CIC_POS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] ev_main,
  input  logic [DW-1:0] ev_ext,
  input  logic          ci_evt,
  input  logic [CW-1:0] ci_code,
  output logic          irq
);
  reg_sel_e      sel;
  logic          rd_main, rd_ext, rd_code;
  logic [DW-1:0] mask_q, pend_q, view, ext_q;
  logic          ext_hit;
  logic [CW-1:0] code_q;

  assign sel     = reg_sel_e'(bus_addr);
  assign rd_main = bus_rd && (sel == SEL_MAIN);
  assign rd_ext  = bus_rd && (sel == SEL_EXT);
  assign rd_code = bus_rd && (sel == SEL_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n)                         mask_q <= '1;
    else if (bus_wr && sel == SEL_MASK) mask_q <= bus_wdata;
  end

  irq_ext_stat #(.DW(DW)) u_ext (
    .clk(clk), .rst_n(rst_n), .ev_ext(ev_ext), .rd_ext(rd_ext),
    .ext_q(ext_q), .ext_hit(ext_hit)
  );

  irq_code_hold #(.CW(CW)) u_code (
    .clk(clk), .rst_n(rst_n), .ci_evt(ci_evt), .ci_code(ci_code),
    .code_q(code_q)
  );

  irq_main_stat #(.DW(DW), .EXD_BIT(EXD_BIT), .CIC_BIT(CIC_BIT)) u_main (
    .clk(clk), .rst_n(rst_n), .ev_main(ev_main), .ext_hit(ext_hit),
    .ci_evt(ci_evt), .rd_main(rd_main), .rd_ext(rd_ext), .rd_code(rd_code),
    .mask(mask_q), .pend_q(pend_q), .view(view)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_MAIN: bus_rdata = view;
        SEL_MASK: bus_rdata = mask_q;
        SEL_EXT:  bus_rdata = ext_q;
        SEL_CODE: bus_rdata[CW-1:0] = code_q;
      endcase
    end
  end

  assign irq = |(pend_q & ~mask_q);
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int DW      = 8,
  parameter int EXD_BIT = 0,
  parameter int CIC_BIT = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic [DW-1:0] ev_main,
  input logic [DW-1:0] ev_ext,
  input logic          irq,
  input logic [DW-1:0] pend_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] ext_q
);
  localparam logic [DW-1:0] CIC_M = DW'(1) << CIC_BIT;
  localparam logic [DW-1:0] EXD_M = DW'(1) << EXD_BIT;
  localparam logic [DW-1:0] NRM_M = ~(CIC_M | EXD_M);

  // R3
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0) |=>
      ((($past(pend_q & mask_q) & NRM_M) & ~pend_q) == '0));

  // R4
  cic_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[CIC_BIT] && !(bus_rd && bus_addr == 2'd3)) |=> pend_q[CIC_BIT]);

  // R5
  ext_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd2 && ev_ext == '0) |=>
      (ext_q == '0 && !pend_q[EXD_BIT]));

  // R6
  exd_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q[EXD_BIT] && !pend_q[EXD_BIT]) |=> !pend_q[EXD_BIT]);

  // R7
  quiet_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0 && !irq) |-> ((bus_rdata & ~CIC_M) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_main & NRM_M) != '0) |=>
      ((pend_q & $past(ev_main & NRM_M)) == $past(ev_main & NRM_M)));
endmodule

bind irq_status_unit irq_status_unit_chk #(
  .DW(DW), .EXD_BIT(EXD_BIT), .CIC_BIT(CIC_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .ev_main(ev_main), .ev_ext(ev_ext), .irq(irq),
  .pend_q(pend_q), .mask_q(mask_q), .ext_q(ext_q)
);

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  localparam int PER = 10;
  localparam int NV  = 42;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [1:0] ad;
    logic [7:0] wd;
    logic [7:0] em;
    logic [7:0] ee;
    logic       ci;
    logic [5:0] cd;
    logic [7:0] xr;
    logic       xi;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(logic rd, logic wr, logic [1:0] ad, logic [7:0] wd,
                              logic [7:0] em, logic [7:0] ee, logic ci, logic [5:0] cd,
                              logic [7:0] xr, logic xi, logic [3:0] rq);
    mk = '{rd, wr, ad, wd, em, ee, ci, cd, xr, xi, rq};
  endfunction

  // rd wr ad wd em ee ci cd | expected rdata, expected irq, requirement
  localparam vec_t TBL [NV] = '{
    mk(1,0,1,8'h00,8'h00,8'h00,0,6'h00, 8'hFF,0,4'd9),  // R9 R1 mask reset value
    mk(0,1,1,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd9),  // R9 unmask all
    mk(0,0,0,8'h00,8'h88,8'h00,0,6'h00, 8'h00,0,4'd2),  // R2
    mk(0,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h00,1,4'd7),  // R7
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h88,1,4'd2),  // R2
    mk(0,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd2),
    mk(0,1,1,8'h80,8'h00,8'h00,0,6'h00, 8'h00,0,4'd3),  // R3
    mk(0,0,0,8'h00,8'h90,8'h00,0,6'h00, 8'h00,0,4'd3),
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h10,1,4'd3),
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd3),
    mk(0,1,1,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd3),
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h80,1,4'd3),
    mk(0,0,0,8'h00,8'h05,8'h00,0,6'h00, 8'h00,0,4'd10), // R10
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd10),
    mk(0,0,0,8'h00,8'h00,8'h00,1,6'h2A, 8'h00,0,4'd4),  // R4
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h04,1,4'd4),
    mk(1,0,3,8'h00,8'h00,8'h00,0,6'h00, 8'h2A,1,4'd4),
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd4),
    mk(0,1,1,8'h04,8'h00,8'h00,0,6'h00, 8'h00,0,4'd4),
    mk(0,0,0,8'h00,8'h00,8'h00,1,6'h15, 8'h00,0,4'd4),
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h04,0,4'd7),  // R7 masked code change
    mk(1,0,3,8'h00,8'h00,8'h00,0,6'h00, 8'h15,0,4'd4),
    mk(0,0,0,8'h00,8'h00,8'h41,0,6'h00, 8'h00,0,4'd5),  // R5
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h01,1,4'd6),  // R6
    mk(1,0,2,8'h00,8'h00,8'h00,0,6'h00, 8'h41,0,4'd5),
    mk(0,0,0,8'h00,8'h00,8'h02,0,6'h00, 8'h00,0,4'd5),
    mk(1,0,2,8'h00,8'h00,8'h00,0,6'h00, 8'h02,1,4'd5),
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd5),
    mk(0,1,1,8'h05,8'h00,8'h00,0,6'h00, 8'h00,0,4'd6),
    mk(0,0,0,8'h00,8'h00,8'h10,0,6'h00, 8'h00,0,4'd6),
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd6),
    mk(0,1,1,8'h04,8'h00,8'h00,0,6'h00, 8'h00,0,4'd6),
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd6),
    mk(1,0,2,8'h00,8'h00,8'h00,0,6'h00, 8'h10,0,4'd5),
    mk(1,0,0,8'h00,8'h20,8'h00,0,6'h00, 8'h00,0,4'd8),  // R8 ordinary bit
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h20,1,4'd8),
    mk(1,0,2,8'h00,8'h00,8'h08,0,6'h00, 8'h00,0,4'd8),  // R8 extended
    mk(1,0,2,8'h00,8'h00,8'h00,0,6'h00, 8'h08,1,4'd8),
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd8),
    mk(1,0,3,8'h00,8'h00,8'h00,1,6'h3F, 8'h15,0,4'd8),  // R8 code bit
    mk(1,0,3,8'h00,8'h00,8'h00,0,6'h00, 8'h3F,0,4'd8),
    mk(1,0,0,8'h00,8'h00,8'h00,0,6'h00, 8'h00,0,4'd8)
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0, ci_evt = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, ev_main = '0, ev_ext = '0, bus_rdata;
  logic [5:0] ci_code = '0;
  logic       irq;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(PER/2) clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_main(ev_main), .ev_ext(ev_ext), .ci_evt(ci_evt), .ci_code(ci_code),
    .irq(irq)
  );

  task automatic cmp(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    bus_rd = v.rd; bus_wr = v.wr; bus_addr = v.ad; bus_wdata = v.wd;
    ev_main = v.em; ev_ext = v.ee; ci_evt = v.ci; ci_code = v.cd;
    #(PER/4);
  endtask

  function automatic vec_t idle();
    idle = '0;
  endfunction

  function automatic vec_t rdv(input logic [1:0] a);
    rdv = '0; rdv.rd = 1'b1; rdv.ad = a;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #(PER/4);
    cmp({7'b0, irq}, 8'h00, "R1 irq after reset");
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      cmp(bus_rdata, TBL[i].xr, $sformatf("R%0d vec %0d rdata", TBL[i].rq, i));
      cmp({7'b0, irq}, {7'b0, TBL[i].xi}, $sformatf("R%0d vec %0d irq", TBL[i].rq, i));
    end
    // R1: reset mid-run clears pending state and re-masks everything
    begin
      vec_t v = '0;
      v.wr = 1'b1; v.ad = 2'd1; v.wd = 8'h00; drive(v);
      v = '0; v.em = 8'h40; v.ee = 8'h03; v.ci = 1'b1; v.cd = 6'h11; drive(v);
      drive(idle());
      cmp({7'b0, irq}, 8'h01, "R7 irq before reset");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      drive(rdv(2'd1)); cmp(bus_rdata, 8'hFF, "R1 mask after reset");
      cmp({7'b0, irq}, 8'h00, "R1 irq after reset");
      drive(rdv(2'd0)); cmp(bus_rdata, 8'h00, "R1 primary after reset");
      drive(rdv(2'd2)); cmp(bus_rdata, 8'h00, "R1 extended after reset");
      drive(rdv(2'd3)); cmp(bus_rdata, 8'h00, "R1 code after reset");
      drive(idle());    cmp(bus_rdata, 8'h00, "R2 no read gives zero data");
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(PER * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule